// File: doc/BRIEF.md
# Serial Receiver with Sticky Line-Error Flags

This block turns an asynchronous serial line into bytes. The line is first brought into the clock domain through a short synchronizer. It is then oversampled on an externally supplied baud tick, sixteen ticks to a bit. A start bit is accepted only if the line is still low at the middle of that bit. Eight data bits are then shifted in least significant bit first. An optional parity bit and a stop bit follow. Each finished byte moves into a single holding register, and software collects it through a small register port.

Three line faults are kept as sticky flags: a bad stop bit, a parity mismatch, and a byte arriving while the holding register is still occupied. Software reads the flags and clears them by writing ones. A master enable gates the receiver. Writing the enable to 0 discards the held byte, clears every flag and stops any frame in progress. The interrupt output combines the buffer-full condition with the error flags, each gated by its own enable. Bytes leave only through the register port, so there is no back-pressure toward the line. When the holding register is full, a new byte is lost: the overrun flag records the loss and the held byte is kept.

Top module: `serial_rx`

## Requirements
- R1: After reset the control register (address 0) and the status register (address 1) read 0, and `rx_full` and `irq` are 0, so the receiver starts disabled.
- R2: With the enable on, the receiver counts 16 baud ticks per bit and checks the start bit 8 ticks after the falling edge. A low pulse that has ended by then starts no frame. Data bits are taken least significant bit first.
- R3: When a frame completes and the holding register is empty, the byte is stored, `rx_full` becomes 1, and status bit 0 reads 1.
- R4: Reading address 2 returns the held byte and clears `rx_full`.
- R5: When the stop bit is sampled as 0, the framing flag (status bit 1) is set.
- R6: Parity is checked only when control bit 1 is 1, and only when a byte moves into the holding register. Control bit 2 selects odd parity when 1 and even parity when 0. A mismatch sets status bit 2.
- R7: When a frame completes while the holding register is full and is not being read in that cycle, the overrun flag (status bit 3) is set and the held byte is kept unchanged.
- R8: Writing 1 to a status error bit clears it, and writing 0 leaves it as it was. If a flag is set by the line in the same cycle as a clear is written, the flag stays set.
- R9: Writing the control register with bit 0 = 0 empties the holding register and clears all three error flags. While the enable is 0, line activity stores nothing.
- R10: Control bits 1, 2 and 3 take a written value only if the enable was 0 before the write. Bit 3 is the buffer-full interrupt enable. Bit 4, the error interrupt enable, and bit 0 always take the written value.
- R11: `irq` is 1 exactly when the buffer is full with control bit 3 set, or when any error flag is set with control bit 4 set.
- R12: A read of address 2 in the same cycle that a frame completes returns the old byte, stores the new one, and sets no overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Asynchronous serial line, idle high |
| baud_tick | input | 1 | One-cycle strobe at 16 times the bit rate |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a read of address 2 consumes the byte) |
| reg_addr | input | 2 | Register address: 0 control, 1 status, 2 data |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| rx_full | output | 1 | Holding register contains an unread byte |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of functions can meet in a single clock cycle. The first pair is software consuming the held byte and the line delivering a new one. The second pair is a write-one-to-clear and the line setting the same error flag. The bench drives the baud tick on every clock, so the cycle in which a frame completes can be worked out in advance. It then starts the register access on that exact cycle, in parallel with the frame. It then judges the outcome at the ports: the collided read must return the old byte, leave the new byte held and raise no overrun, and the collided clear must leave the framing flag at 1.

// File: rtl/srx_pkg.sv
package srx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } srx_state_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  localparam int CTRL_BITS = 5;
  localparam int STAT_BITS = 4;

  // packed: first member is the most significant bit
  typedef struct packed {
    logic err_ie;   // bit 4
    logic full_ie;  // bit 3
    logic par_odd;  // bit 2
    logic par_en;   // bit 1
    logic en;       // bit 0
  } srx_ctrl_t;

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] pipe_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '1;
        else        pipe_q <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '1;
        else        pipe_q <= {pipe_q[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = pipe_q[STAGES-1];

endmodule

// File: rtl/srx_framer.sv
module srx_framer
  import srx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_BITS  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic                 par_en,
  input  logic                 tick,
  input  logic                 line,
  output logic                 done,
  output logic [DATA_BITS-1:0] data,
  output logic                 pbit,
  output logic                 stop_bit
);

  localparam int CNT_W = $clog2(OVERSAMPLE);
  localparam int IDX_W = $clog2(DATA_BITS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVERSAMPLE - 1);
  localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(OVERSAMPLE / 2 - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_BITS - 1);

  srx_state_e           state_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [IDX_W-1:0]     idx_q;
  logic [DATA_BITS-1:0] shreg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      idx_q    <= '0;
      shreg_q  <= '0;
      pbit     <= 1'b0;
      stop_bit <= 1'b1;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!enable) begin
        state_q <= ST_IDLE;
        cnt_q   <= '0;
        idx_q   <= '0;
      end else if (tick) begin
        unique case (state_q)
          ST_IDLE: begin
            if (!line) begin
              state_q <= ST_START;
              cnt_q   <= '0;
            end
          end
          ST_START: begin
            if (cnt_q == CNT_MID) begin
              cnt_q   <= '0;
              idx_q   <= '0;
              state_q <= line ? ST_IDLE : ST_DATA;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_DATA: begin
            if (cnt_q == CNT_LAST) begin
              cnt_q   <= '0;
              shreg_q <= {line, shreg_q[DATA_BITS-1:1]};
              if (idx_q == IDX_LAST) state_q <= par_en ? ST_PAR : ST_STOP;
              else                   idx_q   <= idx_q + 1'b1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_PAR: begin
            if (cnt_q == CNT_LAST) begin
              cnt_q   <= '0;
              pbit    <= line;
              state_q <= ST_STOP;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_STOP: begin
            if (cnt_q == CNT_LAST) begin
              cnt_q    <= '0;
              stop_bit <= line;
              done     <= 1'b1;
              state_q  <= ST_IDLE;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign data = shreg_q;

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  done_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !done);

endmodule

// File: rtl/srx_rxbuf.sv
module srx_rxbuf #(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush,
  input  logic                 pop,
  input  logic                 done,
  input  logic [DATA_BITS-1:0] fr_data,
  input  logic                 fr_pbit,
  input  logic                 fr_stop,
  input  logic                 par_en,
  input  logic                 par_odd,
  output logic                 full,
  output logic [DATA_BITS-1:0] data,
  output logic                 set_fer,
  output logic                 set_per,
  output logic                 set_oer
);

  logic load;
  logic par_bad;

  // a read in the same cycle frees the slot for the arriving byte
  assign load    = done && (!full || pop);
  assign par_bad = ((^fr_data) ^ fr_pbit) != par_odd;
  assign set_oer = done && full && !pop;
  assign set_fer = done && !fr_stop;
  assign set_per = load && par_en && par_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else if (flush) begin
      full <= 1'b0;
    end else if (load) begin
      full <= 1'b1;
      data <= fr_data;
    end else if (pop) begin
      full <= 1'b0;
    end
  end

  // R7
  overrun_keeps_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_oer && !flush) |=> (full && $stable(data)));

  // R3
  full_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full) |-> $past(done));

  // R12
  pop_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && pop && !flush) |=> full);

endmodule

// File: rtl/srx_csr.sv
module srx_csr
  import srx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          rd,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  input  logic          full,
  input  logic [DW-1:0] buf_data,
  input  logic          set_fer,
  input  logic          set_per,
  input  logic          set_oer,
  output srx_ctrl_t     ctrl,
  output logic          flush,
  output logic          pop,
  output logic [DW-1:0] rdata,
  output logic          irq
);

  logic fer_q, per_q, oer_q;
  logic ctrl_wr, stat_wr;
  logic unused_wbits;

  assign ctrl_wr      = wr && (addr == ADDR_CTRL);
  assign stat_wr      = wr && (addr == ADDR_STAT);
  assign flush        = ctrl_wr && !wdata[0];
  assign pop          = rd && (addr == ADDR_DATA);
  assign unused_wbits = ^wdata[DW-1:CTRL_BITS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else if (ctrl_wr) begin
      ctrl.en     <= wdata[0];
      ctrl.err_ie <= wdata[4];
      if (!ctrl.en) begin
        ctrl.par_en  <= wdata[1];
        ctrl.par_odd <= wdata[2];
        ctrl.full_ie <= wdata[3];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fer_q <= 1'b0;
      per_q <= 1'b0;
      oer_q <= 1'b0;
    end else if (flush) begin
      fer_q <= 1'b0;
      per_q <= 1'b0;
      oer_q <= 1'b0;
    end else begin
      fer_q <= set_fer | (fer_q & ~(stat_wr & wdata[1]));
      per_q <= set_per | (per_q & ~(stat_wr & wdata[2]));
      oer_q <= set_oer | (oer_q & ~(stat_wr & wdata[3]));
    end
  end

  always_comb begin
    unique case (addr)
      ADDR_CTRL: rdata = {{(DW-CTRL_BITS){1'b0}}, ctrl};
      ADDR_STAT: rdata = {{(DW-STAT_BITS){1'b0}}, oer_q, per_q, fer_q, full};
      ADDR_DATA: rdata = buf_data;
      default:   rdata = '0;
    endcase
  end

  assign irq = (full & ctrl.full_ie) | ((fer_q | per_q | oer_q) & ctrl.err_ie);

  // R9
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!fer_q && !per_q && !oer_q));

  // R10
  mode_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && ctrl.en) |=> ($stable(ctrl.par_en) && $stable(ctrl.par_odd)
                              && $stable(ctrl.full_ie)));

  // R8
  w1c_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !wdata[1] && fer_q) |=> fer_q);

  // R8
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_oer && !flush) |=> oer_q);

  // R11
  irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.err_ie && !ctrl.full_ie) |-> !irq);

endmodule

// File: rtl/serial_rx.sv
module serial_rx
  import srx_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int DATA_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rxd,
  input  logic                 baud_tick,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [1:0]           reg_addr,
  input  logic [DATA_BITS-1:0] reg_wdata,
  output logic [DATA_BITS-1:0] reg_rdata,
  output logic                 rx_full,
  output logic                 irq
);

  logic                 line_s;
  srx_ctrl_t            ctrl;
  logic                 flush, pop;
  logic                 fr_done, fr_pbit, fr_stop;
  logic [DATA_BITS-1:0] fr_data, buf_data;
  logic                 set_fer, set_per, set_oer;

  srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (rxd),
    .dout (line_s)
  );

  srx_framer #(.OVERSAMPLE(OVERSAMPLE), .DATA_BITS(DATA_BITS)) u_framer (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (ctrl.en),
    .par_en  (ctrl.par_en),
    .tick    (baud_tick),
    .line    (line_s),
    .done    (fr_done),
    .data    (fr_data),
    .pbit    (fr_pbit),
    .stop_bit(fr_stop)
  );

  srx_rxbuf #(.DATA_BITS(DATA_BITS)) u_rxbuf (
    .clk    (clk),
    .rst_n  (rst_n),
    .flush  (flush),
    .pop    (pop),
    .done   (fr_done),
    .fr_data(fr_data),
    .fr_pbit(fr_pbit),
    .fr_stop(fr_stop),
    .par_en (ctrl.par_en),
    .par_odd(ctrl.par_odd),
    .full   (rx_full),
    .data   (buf_data),
    .set_fer(set_fer),
    .set_per(set_per),
    .set_oer(set_oer)
  );

  srx_csr #(.DW(DATA_BITS)) u_csr (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (reg_wr),
    .rd      (reg_rd),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .full    (rx_full),
    .buf_data(buf_data),
    .set_fer (set_fer),
    .set_per (set_per),
    .set_oer (set_oer),
    .ctrl    (ctrl),
    .flush   (flush),
    .pop     (pop),
    .rdata   (reg_rdata),
    .irq     (irq)
  );

endmodule

// File: tb/serial_rx_bench.sv
module serial_rx_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b1;
  logic       baud_tick = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       rx_full;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  int tick_div = 1;
  int div_cnt  = 0;
  bit finished = 0;

  localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_DATA = 2'd2;

  always #5 clk = ~clk;

  serial_rx u_serial_rx (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .baud_tick(baud_tick),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rx_full(rx_full), .irq(irq)
  );

  always @(negedge clk) begin
    div_cnt   = (div_cnt + 1 >= tick_div) ? 0 : div_cnt + 1;
    baud_tick = (div_cnt == 0);
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  function automatic logic par_of(input logic [7:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  // start, 8 data LSB first, optional parity, stop; each bit 16 ticks
  task automatic send_frame(input logic [7:0] d, input bit par_on,
                            input logic pb, input logic stopv);
    @(negedge clk);
    rxd = 1'b0;
    repeat (16 * tick_div) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i];
      repeat (16 * tick_div) @(negedge clk);
    end
    if (par_on) begin
      rxd = pb;
      repeat (16 * tick_div) @(negedge clk);
    end
    rxd = stopv;
    repeat (16 * tick_div) @(negedge clk);
    rxd = 1'b1;
    repeat (8 * tick_div) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    check("R1 rx_full", rx_full, 0);
    check("R1 irq", irq, 0);
    reg_read(A_CTRL, v); check("R1 ctrl", v, 8'h00);
    reg_read(A_STAT, v); check("R1 status", v, 8'h00);
  endtask

  task automatic t_basic;
    logic [7:0] v;
    reg_write(A_CTRL, 8'h01);
    send_frame(8'h1B, 0, 1'b0, 1'b1);
    check("R3 rx_full", rx_full, 1);
    reg_read(A_STAT, v); check("R3 status", v, 8'h01);
    reg_read(A_DATA, v); check("R2 lsb-first byte", v, 8'h1B);
    check("R4 rx_full after read", rx_full, 0);
  endtask

  task automatic t_glitch;
    @(negedge clk); rxd = 1'b0;
    repeat (4) @(negedge clk); rxd = 1'b1;
    repeat (200) @(negedge clk);
    check("R2 glitch ignored", rx_full, 0);
  endtask

  task automatic t_slow;
    logic [7:0] v;
    tick_div = 4;
    send_frame(8'h6E, 0, 1'b0, 1'b1);
    reg_read(A_DATA, v); check("R2 slow tick byte", v, 8'h6E);
    tick_div = 1;
  endtask

  task automatic t_framing;
    logic [7:0] v;
    send_frame(8'h55, 0, 1'b0, 1'b0);
    reg_read(A_STAT, v); check("R5 framing set", v, 8'h03);
    reg_write(A_STAT, 8'h00);
    reg_read(A_STAT, v); check("R8 write zero no effect", v, 8'h03);
    reg_write(A_STAT, 8'h02);
    reg_read(A_STAT, v); check("R8 write one clears", v, 8'h01);
    reg_read(A_DATA, v); check("R5 byte still stored", v, 8'h55);
  endtask

  task automatic t_parity;
    logic [7:0] v;
    reg_write(A_CTRL, 8'h02);
    reg_write(A_CTRL, 8'h03);
    send_frame(8'h35, 1, par_of(8'h35, 1'b0), 1'b1);
    reg_read(A_STAT, v); check("R6 even good", v, 8'h01);
    reg_read(A_DATA, v); check("R6 even data", v, 8'h35);
    send_frame(8'h35, 1, ~par_of(8'h35, 1'b0), 1'b1);
    reg_read(A_STAT, v); check("R6 even bad", v, 8'h05);
    reg_read(A_DATA, v);
    reg_write(A_STAT, 8'h04);
    reg_write(A_CTRL, 8'h00);
    reg_write(A_CTRL, 8'h06);
    reg_write(A_CTRL, 8'h07);
    send_frame(8'hC1, 1, par_of(8'hC1, 1'b1), 1'b1);
    reg_read(A_STAT, v); check("R6 odd good", v, 8'h01);
    reg_read(A_DATA, v);
    send_frame(8'hC1, 1, ~par_of(8'hC1, 1'b1), 1'b1);
    reg_read(A_STAT, v); check("R6 odd bad", v, 8'h05);
    reg_read(A_DATA, v); check("R6 odd data", v, 8'hC1);
    reg_write(A_STAT, 8'h04);
  endtask

  task automatic t_lock;
    logic [7:0] v;
    reg_write(A_CTRL, 8'h01);
    reg_read(A_CTRL, v); check("R10 parity bits locked", v, 8'h07);
    reg_write(A_CTRL, 8'h09);
    reg_read(A_CTRL, v); check("R10 full_ie locked", v, 8'h07);
    reg_write(A_CTRL, 8'h17);
    reg_read(A_CTRL, v); check("R10 err_ie accepted", v, 8'h17);
  endtask

  task automatic t_overrun_irq;
    logic [7:0] v;
    reg_write(A_CTRL, 8'h00);
    reg_write(A_CTRL, 8'h01);
    send_frame(8'h11, 0, 1'b0, 1'b1);
    send_frame(8'h22, 0, 1'b0, 1'b1);
    reg_read(A_STAT, v); check("R7 overrun set", v, 8'h09);
    check("R11 irq masked", irq, 0);
    reg_write(A_CTRL, 8'h11);
    check("R11 irq from error", irq, 1);
    reg_read(A_DATA, v); check("R7 old byte kept", v, 8'h11);
    reg_write(A_STAT, 8'h08);
    check("R11 irq cleared", irq, 0);
    reg_write(A_CTRL, 8'h00);
    reg_write(A_CTRL, 8'h08);
    reg_write(A_CTRL, 8'h09);
    send_frame(8'h77, 0, 1'b0, 1'b1);
    check("R11 irq from full", irq, 1);
    reg_read(A_DATA, v);
    check("R11 irq after read", irq, 0);
  endtask

  task automatic t_flush;
    logic [7:0] v;
    send_frame(8'h3A, 0, 1'b0, 1'b0);
    reg_read(A_STAT, v); check("R5 setup", v, 8'h03);
    reg_write(A_CTRL, 8'h08);
    reg_read(A_STAT, v); check("R9 flush status", v, 8'h00);
    check("R9 flush rx_full", rx_full, 0);
    send_frame(8'h99, 0, 1'b0, 1'b1);
    check("R9 disabled ignores line", rx_full, 0);
    reg_write(A_CTRL, 8'h09);
  endtask

  task automatic t_read_collide;
    logic [7:0] v;
    logic [7:0] rv;
    send_frame(8'h33, 0, 1'b0, 1'b1);
    fork
      send_frame(8'h44, 0, 1'b0, 1'b1);
      begin
        @(negedge clk);
        repeat (154) @(negedge clk);
        reg_read(A_DATA, rv);
      end
    join
    check("R12 collided read old byte", rv, 8'h33);
    reg_read(A_STAT, v); check("R12 no overrun", v, 8'h01);
    reg_read(A_DATA, v); check("R12 new byte stored", v, 8'h44);
  endtask

  task automatic t_clear_collide;
    logic [7:0] v;
    send_frame(8'h5A, 0, 1'b0, 1'b0);
    reg_read(A_DATA, v);
    fork
      send_frame(8'h5B, 0, 1'b0, 1'b0);
      begin
        @(negedge clk);
        repeat (154) @(negedge clk);
        reg_write(A_STAT, 8'h02);
      end
    join
    reg_read(A_STAT, v); check("R8 set wins over clear", v, 8'h03);
    reg_write(A_STAT, 8'h02);
    reg_read(A_STAT, v); check("R8 later clear", v, 8'h01);
    reg_read(A_DATA, v); check("R8 byte", v, 8'h5B);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_basic();
    t_glitch();
    t_slow();
    t_framing();
    t_parity();
    t_lock();
    t_overrun_irq();
    t_flush();
    t_read_collide();
    t_clear_collide();
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

endmodule